// File: doc/BRIEF.md
# Playback sample byte assembler

This block sits behind a write-only host data port and turns a stream of byte writes into one playback sample word for the FIFO that feeds the converters. A small tracker counts how many bytes of the current sample have been taken. Each accepted write fills the next byte lane. When the sample holds as many bytes as the format asks for, any further writes are dropped.

Software polls a status register. The tracker position and a "sample complete" bit are visible there. Reading that register finishes the sample. If the sample is complete and the FIFO has room, the word is pushed to the FIFO. In every case the tracker and the lanes return to empty, ready for the next sample. If the sample is not complete, the read only discards the partial bytes. If the FIFO is full at the moment of the push, the sample is lost and a sticky overrun flag is set.

Top module: `pbk_sample_packer`

## Requirements
- R1: Each accepted write stores `wr_data` in the byte lane given by the current tracker position and advances `stat_pos` by one, visible in the cycle after the write edge.
- R2: While `stat_complete` is 1, writes are ignored: `stat_pos`, `stat_complete` and the word later pushed are unchanged by them.
- R3: `fmt` selects the sample length: 00 gives 1 byte, 01 gives 2 bytes, 10 and 11 give 4 bytes. The byte written k-th (k from 0) occupies `push_data[8k+7:8k]`, in the order left-low, left-high, right-low, right-high.
- R4: A status read (`stat_rd`) while `stat_complete` is 1 and `fifo_full` is 0 raises `push` for exactly one cycle, one cycle after the read edge, with the assembled word on `push_data`. Lanes not written read as zero.
- R5: After any status read, the next cycle shows `stat_pos` = 0 and `stat_complete` = 0.
- R6: A status read while the sample is incomplete produces no push. The partial bytes are discarded, so the next sample starts from all-zero lanes.
- R7: A status read of a complete sample while `fifo_full` is 1 produces no push and sets `stat_ovr` in the next cycle. `stat_ovr` then stays at 1 until reset.
- R8: While `rst_n` is low and after its release, `push`, `stat_complete`, `stat_pos` and `stat_ovr` are all 0.
- R9: A write in the same cycle as a status read is discarded.
- R10: While the sample is complete, `stat_pos` shows the index of the last byte: 0, 1 or 3 for the three lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe for the playback data port |
| wr_data | input | 8 | Byte written by the host |
| fmt | input | 2 | Sample format code selecting 1, 2 or 4 bytes |
| stat_rd | input | 1 | Status register read strobe |
| fifo_full | input | 1 | FIFO cannot accept a word |
| push | output | 1 | One-cycle push strobe toward the FIFO |
| push_data | output | 32 | Assembled sample word |
| stat_complete | output | 1 | All bytes of the current sample written |
| stat_pos | output | 2 | Tracker position (next byte, or last byte when complete) |
| stat_ovr | output | 1 | Sticky flag: a complete sample was lost to a full FIFO |

## Verification
The status fields come straight from the tracker register, so they change one cycle after a write edge. The push strobe and the overrun flag are registered off the status-read edge, so they appear one cycle after it. The bench drives every input on a falling edge and reads the results at the following falling edge. This places each check in the one cycle where the result is due. Right after a push, the bench checks one more falling edge to confirm that the strobe lasted a single cycle.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_PAIR     = 2'b01,
    FMT_STEREO16 = 2'b10,
    FMT_STEREO_X = 2'b11
  } fmt_e;

  // Bytes per sample for a format code, clamped to the lanes available.
  function automatic int unsigned fmt_len(input logic [1:0] f, input int unsigned max_lanes);
    int unsigned n;
    case (fmt_e'(f))
      FMT_MONO8:    n = 1;
      FMT_PAIR:     n = 2;
      FMT_STEREO16: n = 4;
      default:      n = 4;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction

  // Tracker position reported while a sample is complete.
  function automatic int unsigned last_index(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

endpackage

// File: rtl/pbk_tracker.sv
module pbk_tracker #(
  parameter int LANES = 4,
  parameter int POS_W = $clog2(LANES),
  parameter int CNT_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [CNT_W-1:0] sample_len,
  output logic [CNT_W-1:0] cnt,
  output logic             complete,
  output logic [POS_W-1:0] pos
);
  import pbk_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (adv)  cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    complete = (cnt >= sample_len);
    if (complete) pos = POS_W'(last_index(int'(sample_len)));
    else          pos = cnt[POS_W-1:0];
  end

endmodule

// File: rtl/pbk_lanes.sv
module pbk_lanes #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int POS_W  = $clog2(LANES),
  parameter int WORD_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr,
  input  logic [POS_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              lane_hit;
    assign lane_hit = wr && (wr_idx == POS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q <= '0;
      else if (clr)      lane_q <= '0;
      else if (lane_hit) lane_q <= wr_data;
    end

    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/pbk_push.sv
module pbk_push #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              drop,
  input  logic [WORD_W-1:0] word_in,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              ovr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push      <= 1'b0;
      push_data <= '0;
      ovr       <= 1'b0;
    end else begin
      push <= commit;
      if (commit) push_data <= word_in;
      if (drop)   ovr <= 1'b1;
    end
  end

endmodule

// File: rtl/pbk_sample_packer.sv
module pbk_sample_packer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [1:0]              fmt,
  input  logic                    stat_rd,
  input  logic                    fifo_full,
  output logic                    push,
  output logic [LANES*BYTE_W-1:0] push_data,
  output logic                    stat_complete,
  output logic [$clog2(LANES)-1:0] stat_pos,
  output logic                    stat_ovr
);
  import pbk_pkg::*;

  localparam int POS_W  = $clog2(LANES);
  localparam int CNT_W  = POS_W + 1;
  localparam int WORD_W = LANES * BYTE_W;

  logic [CNT_W-1:0]  sample_len;
  logic [CNT_W-1:0]  trk_cnt;
  logic              trk_complete;
  logic [POS_W-1:0]  trk_pos;
  logic [WORD_W-1:0] lane_word;

  // Named internal events
  logic wr_accept;   // byte taken into a lane
  logic rd_commit;   // status read pushes the sample
  logic drop_full;   // status read loses the sample to a full FIFO

  assign sample_len = CNT_W'(fmt_len(fmt, LANES));
  assign wr_accept  = wr_en && !stat_rd && !trk_complete;
  assign rd_commit  = stat_rd && trk_complete && !fifo_full;
  assign drop_full  = stat_rd && trk_complete && fifo_full;

  pbk_tracker #(.LANES(LANES), .POS_W(POS_W), .CNT_W(CNT_W)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (wr_accept),
    .clr        (stat_rd),
    .sample_len (sample_len),
    .cnt        (trk_cnt),
    .complete   (trk_complete),
    .pos        (trk_pos)
  );

  pbk_lanes #(.LANES(LANES), .BYTE_W(BYTE_W), .POS_W(POS_W), .WORD_W(WORD_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_accept),
    .clr     (stat_rd),
    .wr_idx  (trk_cnt[POS_W-1:0]),
    .wr_data (wr_data),
    .word    (lane_word)
  );

  pbk_push #(.WORD_W(WORD_W)) u_push (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (rd_commit),
    .drop      (drop_full),
    .word_in   (lane_word),
    .push      (push),
    .push_data (push_data),
    .ovr       (stat_ovr)
  );

  assign stat_complete = trk_complete;
  assign stat_pos      = trk_pos;

endmodule

// File: rtl/pbk_sample_packer_checker.sv
module pbk_sample_packer_checker #(
  parameter int POS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             stat_rd,
  input logic             push,
  input logic             stat_complete,
  input logic [POS_W-1:0] stat_pos,
  input logic             stat_ovr,
  input logic             rd_commit,
  input logic             drop_full
);

  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_rd && !stat_complete) |=>
      (stat_complete || stat_pos == $past(stat_pos) + POS_W'(1)));

  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_rd && stat_complete) |=> (stat_complete && $stable(stat_pos)));

  a_r4_push_due: assert property (@(posedge clk) disable iff (!rst_n)
    rd_commit |=> push);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  a_r5_tracker_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_pos == '0 && !stat_complete));

  a_r6_no_partial_push: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !stat_complete) |=> !push);

  a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    drop_full |=> (stat_ovr && !push));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovr |=> stat_ovr);

endmodule

bind pbk_sample_packer pbk_sample_packer_checker #(.POS_W(POS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .stat_rd       (stat_rd),
  .push          (push),
  .stat_complete (stat_complete),
  .stat_pos      (stat_pos),
  .stat_ovr      (stat_ovr),
  .rd_commit     (rd_commit),
  .drop_full     (drop_full)
);

// File: tb/pbk_sample_packer_bench.sv
module pbk_sample_packer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  fmt = 2'b00;
  logic        stat_rd = 1'b0;
  logic        fifo_full = 1'b0;
  logic        push;
  logic [31:0] push_data;
  logic        stat_complete;
  logic [1:0]  stat_pos;
  logic        stat_ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbk_sample_packer u_pbk_sample_packer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fmt(fmt),
    .stat_rd(stat_rd), .fifo_full(fifo_full), .push(push), .push_data(push_data),
    .stat_complete(stat_complete), .stat_pos(stat_pos), .stat_ovr(stat_ovr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bytes_for(input logic [1:0] f);
    if (f[1]) return 4;
    return f[0] ? 2 : 1;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Status read: returns the pushed flag and word one cycle after the read edge.
  task automatic read_status(output logic pushed, output logic [31:0] word);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    pushed = push;
    word = push_data;
  endtask

  task automatic t_reset;
    check("R8", "push", 32'(push), 0);
    check("R8", "complete", 32'(stat_complete), 0);
    check("R8", "pos", 32'(stat_pos), 0);
    check("R8", "ovr", 32'(stat_ovr), 0);
  endtask

  task automatic t_fill(input logic [1:0] f, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0]  bs [4];
    logic [31:0] exp;
    logic        pushed;
    logic [31:0] word;
    int n;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    fmt = f; n = bytes_for(f); exp = '0;
    for (int k = 0; k < n; k++) begin
      put_byte(bs[k]);
      exp = exp | (32'(bs[k]) << (8*k));
      if (k < n-1) check("R1", "pos after write", 32'(stat_pos), 32'(k+1));
    end
    check("R3", "complete at length", 32'(stat_complete), 1);
    check("R10", "last index", 32'(stat_pos), 32'(n-1));
    read_status(pushed, word);
    check("R4", "push strobe", 32'(pushed), 1);
    check("R4", "push word", word, exp);
    check("R5", "pos cleared", 32'(stat_pos), 0);
    check("R5", "complete cleared", 32'(stat_complete), 0);
    @(negedge clk);
    check("R4", "single pulse", 32'(push), 0);
  endtask

  task automatic t_extra_writes;
    logic pushed; logic [31:0] word;
    fmt = 2'b00;
    put_byte(8'h5A);
    put_byte(8'hFF);
    put_byte(8'hEE);
    check("R2", "complete held", 32'(stat_complete), 1);
    check("R2", "pos held", 32'(stat_pos), 0);
    read_status(pushed, word);
    check("R2", "push after extras", 32'(pushed), 1);
    check("R2", "word unchanged", word, 32'h0000_005A);
  endtask

  task automatic t_partial;
    logic pushed; logic [31:0] word;
    fmt = 2'b10;
    put_byte(8'h11);
    put_byte(8'h22);
    read_status(pushed, word);
    check("R6", "no partial push", 32'(pushed), 0);
    check("R6", "pos cleared", 32'(stat_pos), 0);
    fmt = 2'b01;
    put_byte(8'h77);
    put_byte(8'h66);
    read_status(pushed, word);
    check("R6", "fresh push", 32'(pushed), 1);
    check("R6", "no leftover bytes", word, 32'h0000_6677);
  endtask

  task automatic t_full;
    logic pushed; logic [31:0] word;
    fmt = 2'b01;
    put_byte(8'hAB);
    put_byte(8'hCD);
    fifo_full = 1'b1;
    read_status(pushed, word);
    fifo_full = 1'b0;
    check("R7", "no push when full", 32'(pushed), 0);
    check("R7", "overrun set", 32'(stat_ovr), 1);
    put_byte(8'h01);
    put_byte(8'h02);
    read_status(pushed, word);
    check("R7", "later push ok", 32'(pushed), 1);
    check("R7", "overrun sticky", 32'(stat_ovr), 1);
  endtask

  task automatic t_simultaneous;
    logic pushed; logic [31:0] word;
    fmt = 2'b01;
    put_byte(8'h10);
    wr_en = 1'b1; wr_data = 8'h99; stat_rd = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; stat_rd = 1'b0;
    check("R9", "write with read dropped", 32'(stat_pos), 0);
    put_byte(8'h21);
    put_byte(8'h43);
    read_status(pushed, word);
    check("R9", "word without dropped byte", word, 32'h0000_4321);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill(2'b10, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    t_fill(2'b11, 8'h01, 8'h23, 8'h45, 8'h67);
    t_fill(2'b01, 8'h34, 8'h12, 8'h00, 8'h00);
    t_fill(2'b00, 8'h9C, 8'h00, 8'h00, 8'h00);
    t_extra_writes();
    t_partial();
    t_simultaneous();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule